// File: doc/BRIEF.md
# Oscillator Frequency Meter

This block measures how fast an on-chip oscillator runs relative to the reference clock that drives the block. Software first sets a window length, counted in reference cycles. It then sets the meter enable. While the window is open, the block counts rising edges of the oscillator. When the window closes, it stores the count in a result register and raises a sticky completion flag. A separate free-run enable gates the oscillator. Edges are counted only while that enable and the meter enable are both set.

The oscillator arrives as an asynchronous level stream. It passes through a two-stage synchronizer and an edge detector in the reference domain before it is counted. Software reaches the block through a small register window on a simple synchronous bus. Writes take effect at the clock edge and reads are combinational. A result of zero with the flag set means the oscillator was not detected, and software can read that outcome directly.

Top module: `fm_meter`

## Requirements
- R1: After reset, the control, status and result registers all read zero, and `osc_run_en` is low.
- R2: The control register sits at byte offset 0x0. Its bits 23:0 hold the window length and bit 24 holds the meter enable. Both fields read back as written.
- R3: The status register sits at offset 0x4. Bit 8 is the free-run enable and can be read and written. Bit 0 is the completion flag and is read-only, so a write to it has no effect.
- R4: The result register sits at offset 0x8 and returns the latched edge count as a full 32-bit word.
- R5: A control write that takes the meter enable from 0 to 1 with a nonzero length N opens a window of exactly N reference cycles. When the window closes, the number of synchronized oscillator rising edges seen in it is latched into the result, and the flag is set.
- R6: A 0-to-1 transition of the meter enable clears the completion flag in the same clock edge that captures the write.
- R7: Arming with a window length of zero starts no measurement. The flag stays low and the result keeps its previous value.
- R8: Clearing the meter enable while a window is open aborts it. The flag stays low and the result keeps its previous value.
- R9: While the free-run enable is low, `osc_run_en` is low and no edges are counted. A window then completes with a result of zero and the flag set.
- R10: A control write that leaves the meter enable set, whatever its new length, neither restarts nor resizes a window already in progress.
- R11: Once set, the completion flag stays set until the next arm, even if the meter enable is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| osc_in | input | 1 | Oscillator signal under measurement, asynchronous |
| bus_wr | input | 1 | Write strobe, captured on the rising clock edge |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| osc_run_en | output | 1 | Free-run enable driven to the oscillator gate |

## Verification
The bench drives the oscillator with a steady period that divides the window length. The expected count is then exact whatever the phase: 256 for 1024 cycles at period 4, and 1 for a two-cycle window at period 2. A window that is off by one cycle, or a synchronizer that double counts, misses those values. The bench arms with a zero length and aborts halfway through a window. A design that started anyway, or that latched a partial count, would raise the flag or overwrite the earlier result. The bench also rewrites the control register during a run without an enable transition; a design that restarted on every write would return the short window's count. Finally, it runs a window with the free-run enable off, which must report zero with the flag set.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam logic [3:0] OFS_CTRL  = 4'h0;
  localparam logic [3:0] OFS_STAT  = 4'h4;
  localparam logic [3:0] OFS_RES   = 4'h8;
  localparam int unsigned FRCK_BIT  = 8;
  localparam int unsigned VALID_BIT = 0;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } fm_state_e;
endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= async_in;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b0;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  assign rise_pulse = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/fm_regs.sv
module fm_regs
  import fm_pkg::*;
#(
  parameter int unsigned WIN_W  = 24,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              valid,
  input  logic [DATA_W-1:0] result,
  output logic              meter_en,
  output logic              frck_en,
  output logic              arm,
  output logic [WIN_W-1:0]  arm_len
);
  localparam int unsigned EN_POS = WIN_W;

  logic [WIN_W-1:0] win_q;
  logic             en_q;
  logic             frck_q;
  logic             ctrl_ld;
  logic             stat_ld;
  logic             unused_wd;

  assign ctrl_ld   = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign stat_ld   = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
  assign arm       = ctrl_ld && bus_wdata[EN_POS] && !en_q;
  assign arm_len   = bus_wdata[WIN_W-1:0];
  assign unused_wd = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      en_q  <= 1'b0;
    end else if (ctrl_ld) begin
      win_q <= bus_wdata[WIN_W-1:0];
      en_q  <= bus_wdata[EN_POS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       frck_q <= 1'b0;
    else if (stat_ld) frck_q <= bus_wdata[FRCK_BIT];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_CTRL)) begin
      bus_rdata[WIN_W-1:0] = win_q;
      bus_rdata[EN_POS]    = en_q;
    end else if (bus_addr == ADDR_W'(OFS_STAT)) begin
      bus_rdata[FRCK_BIT]  = frck_q;
      bus_rdata[VALID_BIT] = valid;
    end else if (bus_addr == ADDR_W'(OFS_RES)) begin
      bus_rdata = result;
    end
  end

  assign meter_en = en_q;
  assign frck_en  = frck_q;
endmodule

// File: rtl/fm_window.sv
module fm_window
  import fm_pkg::*;
#(
  parameter int unsigned WIN_W = 24,
  parameter int unsigned CNT_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [WIN_W-1:0] arm_len,
  input  logic             meter_en,
  input  logic             frck_en,
  input  logic             osc_pulse,
  output logic             busy,
  output logic             valid,
  output logic [CNT_W-1:0] result
);
  fm_state_e        state_q, state_n;
  logic [WIN_W-1:0] len_q, len_n;
  logic [WIN_W-1:0] tick_q, tick_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] res_q, res_n;
  logic             vld_q, vld_n;
  logic [CNT_W-1:0] cnt_inc;
  logic             last_tick;

  assign cnt_inc   = cnt_q + CNT_W'(frck_en & osc_pulse);
  assign last_tick = (tick_q == (len_q - 1'b1));

  always_comb begin
    state_n = state_q;
    len_n   = len_q;
    tick_n  = tick_q;
    cnt_n   = cnt_q;
    res_n   = res_q;
    vld_n   = vld_q;
    if (arm) begin
      vld_n   = 1'b0;
      len_n   = arm_len;
      tick_n  = '0;
      cnt_n   = '0;
      state_n = (arm_len != '0) ? ST_RUN : ST_IDLE;
    end else if (state_q == ST_RUN) begin
      if (!meter_en) begin
        state_n = ST_IDLE;
      end else begin
        tick_n = tick_q + 1'b1;
        cnt_n  = cnt_inc;
        if (last_tick) begin
          res_n   = cnt_inc;
          vld_n   = 1'b1;
          state_n = ST_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      tick_q  <= '0;
      cnt_q   <= '0;
      res_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      len_q   <= len_n;
      tick_q  <= tick_n;
      cnt_q   <= cnt_n;
      res_q   <= res_n;
      vld_q   <= vld_n;
    end
  end

  assign busy   = (state_q == ST_RUN);
  assign valid  = vld_q;
  assign result = res_q;
endmodule

// File: rtl/fm_meter.sv
module fm_meter #(
  parameter int unsigned WIN_W       = 24,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              osc_run_en
);
  localparam int unsigned CNT_W = WIN_W + 1;

  logic [1:0]       rst_pipe;
  logic             rst_n_s;
  logic             meter_en;
  logic             frck_en;
  logic             arm;
  logic [WIN_W-1:0] arm_len;
  logic             osc_gated;
  logic             osc_pulse;
  logic             busy;
  logic             valid;
  logic [CNT_W-1:0] result_cnt;
  logic [DATA_W-1:0] result_word;

  // reset asserts at once and leaves two reference edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  assign osc_gated   = osc_in & frck_en;
  assign osc_run_en  = frck_en;
  assign result_word = {{(DATA_W-CNT_W){1'b0}}, result_cnt};

  fm_regs #(.WIN_W(WIN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .valid     (valid),
    .result    (result_word),
    .meter_en  (meter_en),
    .frck_en   (frck_en),
    .arm       (arm),
    .arm_len   (arm_len)
  );

  fm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .async_in   (osc_gated),
    .rise_pulse (osc_pulse)
  );

  fm_window #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_win (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .arm       (arm),
    .arm_len   (arm_len),
    .meter_en  (meter_en),
    .frck_en   (frck_en),
    .osc_pulse (osc_pulse),
    .busy      (busy),
    .valid     (valid),
    .result    (result_cnt)
  );
endmodule

// File: rtl/fm_meter_chk.sv
module fm_meter_chk #(
  parameter int unsigned WIN_W = 24,
  parameter int unsigned CNT_W = 25
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic [WIN_W-1:0] arm_len,
  input logic             meter_en,
  input logic             busy,
  input logic             valid,
  input logic [CNT_W-1:0] result
);
  assert_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && arm_len != '0) |=> (busy && !valid));

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid) |-> $past(arm));

  assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && arm_len == '0) |=> (!busy && !valid));

  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !meter_en && !arm) |=> (!busy && !valid));

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $rose(valid));

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !arm) |=> valid);
endmodule

bind fm_meter fm_meter_chk #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .arm      (arm),
  .arm_len  (arm_len),
  .meter_en (meter_en),
  .busy     (busy),
  .valid    (valid),
  .result   (result_cnt)
);

// File: tb/sim_fm_meter.sv
module sim_fm_meter;
  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_STAT = 4'h4;
  localparam logic [3:0] A_RES  = 4'h8;
  localparam logic [31:0] EN    = 32'h0100_0000;

  logic        clk;
  logic        rst_n;
  logic        osc_in;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        osc_run_en;

  int          checks;
  int          errors;
  int          osc_half;
  logic [31:0] got;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  event        res_ev;

  fm_meter u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_in     (osc_in),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .osc_run_en (osc_run_en)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // oscillator: toggles 3 ns after a reference edge, period 2*osc_half cycles
  initial begin
    osc_in = 1'b0;
    #7;
    forever begin
      #(osc_half * 8);
      osc_in = ~osc_in;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_flag(input int limit);
    logic [31:0] s;
    for (int i = 0; i < limit; i++) begin
      rd(A_STAT, s);
      if (s[0]) break;
      @(negedge clk);
    end
  endtask

  task automatic settle(input int half);
    osc_half = half;
    repeat (8 * half + 8) @(negedge clk);
  endtask

  // driver: queue the expected count, run one window, hand the result over
  task automatic measure(input int len, input int half, input logic [31:0] exp, input string req);
    settle(half);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, EN | 32'(len));
    wait_flag(len + 50);
    rd(A_RES, got);
    -> res_ev;
    @(negedge clk);
  endtask

  // monitor: compare each produced result with the next expected item
  initial begin
    forever begin
      logic [31:0] e;
      string t;
      @(res_ev);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, got, e);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] last_res;
    checks = 0; errors = 0; osc_half = 2;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_CTRL, d); check("R1 ctrl", d, 32'h0);
    rd(A_STAT, d); check("R1 stat", d, 32'h0);
    rd(A_RES, d);  check("R1 result", d, 32'h0);
    check("R1 osc_run_en", {31'h0, osc_run_en}, 32'h0);

    // R2 control layout readback without arming
    wr(A_CTRL, 32'h00AB_CDEF);
    rd(A_CTRL, d); check("R2 ctrl readback", d, 32'h00AB_CDEF);
    wr(A_CTRL, 32'h0);

    // R3 free-run bit writable, flag bit read-only
    wr(A_STAT, 32'h0000_0101);
    rd(A_STAT, d); check("R3 stat readback", d, 32'h0000_0100);
    check("R9 osc_run_en follows bit 8", {31'h0, osc_run_en}, 32'h1);

    // R5 and R4 windows with periods that divide the length
    measure(1024, 2, 32'd256, "R5 N=1024 T=4");
    measure(64, 4, 32'd8, "R5 N=64 T=8");
    measure(100, 5, 32'd10, "R4 N=100 T=10");
    measure(2, 1, 32'd1, "R5 N=2 T=2");

    // R11 flag survives clearing the enable
    wr(A_CTRL, 32'd2);
    rd(A_STAT, d); check("R11 flag sticky", d, 32'h0000_0101);
    rd(A_RES, d);  check("R11 result kept", d, 32'd1);

    // R6 re-arm clears the flag at once, then completes
    settle(2);
    exp_q.push_back(32'd50);
    tag_q.push_back("R6 re-armed count");
    wr(A_CTRL, EN | 32'd200);
    rd(A_STAT, d); check("R6 flag cleared on arm", d, 32'h0000_0100);
    wait_flag(300);
    rd(A_RES, got);
    -> res_ev;
    @(negedge clk);
    last_res = 32'd50;

    // R7 zero-length arm
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, EN);
    repeat (50) @(negedge clk);
    rd(A_STAT, d); check("R7 no flag", d, 32'h0000_0100);
    rd(A_RES, d);  check("R7 result kept", d, last_res);

    // R8 abort mid-window
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, EN | 32'd1000);
    repeat (20) @(negedge clk);
    wr(A_CTRL, 32'h0);
    repeat (1100) @(negedge clk);
    rd(A_STAT, d); check("R8 no flag after abort", d, 32'h0000_0100);
    rd(A_RES, d);  check("R8 result kept", d, last_res);

    // R9 free-run gate off gives zero with the flag set
    wr(A_STAT, 32'h0);
    check("R9 osc_run_en low", {31'h0, osc_run_en}, 32'h0);
    measure(64, 2, 32'd0, "R9 gated count");
    rd(A_STAT, d); check("R9 flag with zero", d, 32'h0000_0001);
    wr(A_STAT, 32'h0000_0100);

    // R10 a write with enable still set does not restart the window
    settle(2);
    exp_q.push_back(32'd32);
    tag_q.push_back("R10 no restart");
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, EN | 32'd128);
    repeat (10) @(negedge clk);
    wr(A_CTRL, EN | 32'd8);
    wait_flag(300);
    rd(A_RES, got);
    -> res_ev;
    @(negedge clk);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule